// File: doc/BRIEF.md
# Per-Lane Link Delay Table

This block measures how long a signal takes to cross each lane between this node and a remote master, and how far the two clocks are apart. A measurement is a three-way exchange. The master opens it with its send time. This node then records, for each lane, the time that opening packet arrived and the time its own reply left. Finally the master returns, lane by lane, the time the reply reached it. Once all four times for a lane are known, the block assumes the two directions have equal delay. It solves for the one-way delay and the clock offset, and files the delay in a table addressed by lane and initiator device number.

Timestamps arrive as parallel words with a strobe and a lane number, already taken from the lane receive and transmit paths. Time synchronization logic elsewhere reads back a stored delay through a registered lookup port. Cable delays do not change once a system is assembled, so an entry keeps its value until a later exchange from the same initiator on the same lane overwrites it.

Top module: `linkDelayTable`

## Requirements
- R1: A start pulse (`chkStb`) with `chkMaster`=1 latches `chkT1` and `chkDev`. It clears every lane's captured receive and reply times and all error flags. A start pulse with `chkMaster`=0 changes nothing.
- R2: A `t2Stb` pulse stores `t2Time` as the receive time of lane `t2Lane`. Each lane keeps its own value.
- R3: A `t3Stb` pulse stores `t3Time` as the reply send time of lane `t3Lane`. Each lane keeps its own value.
- R4: An `ackStb` on a lane that holds both times commits that lane. All differences are taken modulo 2^TS_W and read as signed values. On the next cycle `resStb`=1, `resLane` is the lane, and `resDelay` = floor(((t2-t1)+(t4-t3))/2). The same delay is written to the table entry {lane, initiator}.
- R5: On the same cycle, `resOffset` = floor(((t2-t1)-(t4-t3))/2).
- R6: An `ackStb` on a lane lacking t2, t3 or both sets bit `ackLane` of `errFlags` on the next cycle. It raises no `resStb` and writes nothing to the table.
- R7: A commit uses up that lane's captured t2 and t3. A second `ackStb` on that lane without new captures is treated as in R6.
- R8: After reset every table entry is invalid. A lookup of an invalid entry gives `rdValid`=0 and `rdDelay`=0.
- R9: A lookup returns `rdValid` and `rdDelay` for address {`rdLane`, `rdDev`} one cycle after the address is presented. If a commit writes the same entry in that cycle, the old contents are returned, and the new value shows one cycle later.
- R10: An entry keeps its delay through later exchanges that commit other lanes or other initiators.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chkStb | input | 1 | Start of a measurement exchange |
| chkMaster | input | 1 | Sender of the start is a bus master |
| chkDev | input | DEV_W | Device number of the initiator |
| chkT1 | input | TS_W | Initiator send time |
| t2Stb | input | 1 | Receive time capture strobe |
| t2Lane | input | LANE_W | Lane of the receive time |
| t2Time | input | TS_W | Receive time |
| t3Stb | input | 1 | Reply send time capture strobe |
| t3Lane | input | LANE_W | Lane of the reply time |
| t3Time | input | TS_W | Reply send time |
| ackStb | input | 1 | Acknowledgement received |
| ackLane | input | LANE_W | Lane of the acknowledgement |
| ackT4 | input | TS_W | Initiator receive time from the acknowledgement |
| rdLane | input | LANE_W | Lookup lane |
| rdDev | input | DEV_W | Lookup initiator device |
| rdValid | output | 1 | Looked-up entry holds a measurement |
| rdDelay | output | TS_W | Looked-up delay |
| resStb | output | 1 | A lane was committed last cycle |
| resLane | output | LANE_W | Committed lane |
| resDelay | output | TS_W | Computed one-way delay |
| resOffset | output | TS_W | Computed clock offset |
| errFlags | output | NUM_LANES | Per-lane incomplete-acknowledgement flags |

## Verification
The hardest case to reach from the ports is a lookup that lands on the very entry being overwritten. The stimulus first fills an entry, then opens a new exchange from the same initiator with different timings. It presents that entry's address in the cycle the acknowledgement commits, and keeps it there one more cycle. The bench also sends acknowledgements on lanes that hold only one captured time or none, and on a lane that has already been used up. Timestamps are placed across the 2^32 wrap, with odd sums and negative offsets, so that modular subtraction and the rounding of the halving are both exercised.

// File: rtl/ldmPkg.sv
package ldmPkg;
  // Strobes passed from the control to the datapath
  typedef struct packed {
    logic ldT1;    // accepted start of an exchange
    logic capT2;   // store a receive time
    logic capT3;   // store a reply send time
    logic commit;  // lane complete: compute and write table
  } ldmStrobes_t;
endpackage

// File: rtl/ldmCtrl.sv
module ldmCtrl
  import ldmPkg::*;
#(
  parameter int NUM_LANES = 8,
  localparam int LANE_W = $clog2(NUM_LANES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chkStb,
  input  logic              chkMaster,
  input  logic              t2Stb,
  input  logic [LANE_W-1:0] t2Lane,
  input  logic              t3Stb,
  input  logic [LANE_W-1:0] t3Lane,
  input  logic              ackStb,
  input  logic [LANE_W-1:0] ackLane,
  output ldmStrobes_t       stb,
  output logic [NUM_LANES-1:0] errFlags
);
  logic [NUM_LANES-1:0] haveT2;
  logic [NUM_LANES-1:0] haveT3;
  logic ackOk;

  always_comb begin
    ackOk      = ackStb && haveT2[ackLane] && haveT3[ackLane];
    stb.ldT1   = chkStb && chkMaster;
    stb.capT2  = t2Stb;
    stb.capT3  = t3Stb;
    stb.commit = ackOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      haveT2   <= '0;
      haveT3   <= '0;
      errFlags <= '0;
    end else begin
      if (stb.ldT1) begin
        haveT2   <= '0;
        haveT3   <= '0;
        errFlags <= '0;
      end
      if (ackOk) begin
        haveT2[ackLane] <= 1'b0;
        haveT3[ackLane] <= 1'b0;
      end
      if (ackStb && !ackOk) errFlags[ackLane] <= 1'b1;
      if (stb.capT2) haveT2[t2Lane] <= 1'b1;
      if (stb.capT3) haveT3[t3Lane] <= 1'b1;
    end
  end
endmodule

// File: rtl/ldmData.sv
module ldmData
  import ldmPkg::*;
#(
  parameter int NUM_LANES = 8,
  parameter int DEV_W = 5,
  parameter int TS_W = 32,
  localparam int LANE_W = $clog2(NUM_LANES),
  localparam int ADDR_W = LANE_W + DEV_W,
  localparam int ENTRIES = NUM_LANES << DEV_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ldmStrobes_t       stb,
  input  logic [DEV_W-1:0]  chkDev,
  input  logic [TS_W-1:0]   chkT1,
  input  logic [LANE_W-1:0] t2Lane,
  input  logic [TS_W-1:0]   t2Time,
  input  logic [LANE_W-1:0] t3Lane,
  input  logic [TS_W-1:0]   t3Time,
  input  logic [LANE_W-1:0] ackLane,
  input  logic [TS_W-1:0]   ackT4,
  input  logic [LANE_W-1:0] rdLane,
  input  logic [DEV_W-1:0]  rdDev,
  output logic              rdValid,
  output logic [TS_W-1:0]   rdDelay,
  output logic              resStb,
  output logic [LANE_W-1:0] resLane,
  output logic [TS_W-1:0]   resDelay,
  output logic [TS_W-1:0]   resOffset
);
  logic [TS_W-1:0]  t1Q;
  logic [DEV_W-1:0] devQ;
  logic [TS_W-1:0]  t2Q [NUM_LANES];
  logic [TS_W-1:0]  t3Q [NUM_LANES];
  logic [TS_W-1:0]  tbl [ENTRIES];
  logic [ENTRIES-1:0] vld;

  // Per-lane timestamp registers
  for (genvar g = 0; g < NUM_LANES; g++) begin : gLane
    always_ff @(posedge clk) begin
      if (!rstN) begin
        t2Q[g] <= '0;
        t3Q[g] <= '0;
      end else begin
        if (stb.capT2 && t2Lane == LANE_W'(g)) t2Q[g] <= t2Time;
        if (stb.capT3 && t3Lane == LANE_W'(g)) t3Q[g] <= t3Time;
      end
    end
  end

  // Modular differences, sign-extended by one bit before add/sub
  logic [TS_W-1:0] fwd, rev;
  logic [TS_W:0]   sumW, difW;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  always_comb begin
    fwd    = t2Q[ackLane] - t1Q;
    rev    = ackT4 - t3Q[ackLane];
    sumW   = {fwd[TS_W-1], fwd} + {rev[TS_W-1], rev};
    difW   = {fwd[TS_W-1], fwd} - {rev[TS_W-1], rev};
    wrAddr = {ackLane, devQ};
    rdAddr = {rdLane, rdDev};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      t1Q       <= '0;
      devQ      <= '0;
      vld       <= '0;
      resStb    <= 1'b0;
      resLane   <= '0;
      resDelay  <= '0;
      resOffset <= '0;
      rdValid   <= 1'b0;
      rdDelay   <= '0;
    end else begin
      if (stb.ldT1) begin
        t1Q  <= chkT1;
        devQ <= chkDev;
      end
      resStb <= stb.commit;
      if (stb.commit) begin
        resLane     <= ackLane;
        resDelay    <= sumW[TS_W:1];   // arithmetic halve = floor
        resOffset   <= difW[TS_W:1];
        vld[wrAddr] <= 1'b1;
      end
      rdValid <= vld[rdAddr];
      rdDelay <= vld[rdAddr] ? tbl[rdAddr] : '0;
    end
  end

  // Table storage, no reset: validity is carried by vld
  always_ff @(posedge clk) begin
    if (stb.commit) tbl[wrAddr] <= sumW[TS_W:1];
  end
endmodule

// File: rtl/linkDelayTable.sv
module linkDelayTable
  import ldmPkg::*;
#(
  parameter int NUM_LANES = 8,   // power of two
  parameter int DEV_W = 5,
  parameter int TS_W = 32,
  localparam int LANE_W = $clog2(NUM_LANES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 chkStb,
  input  logic                 chkMaster,
  input  logic [DEV_W-1:0]     chkDev,
  input  logic [TS_W-1:0]      chkT1,
  input  logic                 t2Stb,
  input  logic [LANE_W-1:0]    t2Lane,
  input  logic [TS_W-1:0]      t2Time,
  input  logic                 t3Stb,
  input  logic [LANE_W-1:0]    t3Lane,
  input  logic [TS_W-1:0]      t3Time,
  input  logic                 ackStb,
  input  logic [LANE_W-1:0]    ackLane,
  input  logic [TS_W-1:0]      ackT4,
  input  logic [LANE_W-1:0]    rdLane,
  input  logic [DEV_W-1:0]     rdDev,
  output logic                 rdValid,
  output logic [TS_W-1:0]      rdDelay,
  output logic                 resStb,
  output logic [LANE_W-1:0]    resLane,
  output logic [TS_W-1:0]      resDelay,
  output logic [TS_W-1:0]      resOffset,
  output logic [NUM_LANES-1:0] errFlags
);
  ldmStrobes_t stb;

  ldmCtrl #(.NUM_LANES(NUM_LANES)) uCtrl (
    .clk(clk), .rstN(rstN), .chkStb(chkStb), .chkMaster(chkMaster),
    .t2Stb(t2Stb), .t2Lane(t2Lane), .t3Stb(t3Stb), .t3Lane(t3Lane),
    .ackStb(ackStb), .ackLane(ackLane), .stb(stb), .errFlags(errFlags)
  );

  ldmData #(.NUM_LANES(NUM_LANES), .DEV_W(DEV_W), .TS_W(TS_W)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .chkDev(chkDev), .chkT1(chkT1),
    .t2Lane(t2Lane), .t2Time(t2Time), .t3Lane(t3Lane), .t3Time(t3Time),
    .ackLane(ackLane), .ackT4(ackT4), .rdLane(rdLane), .rdDev(rdDev),
    .rdValid(rdValid), .rdDelay(rdDelay), .resStb(resStb), .resLane(resLane),
    .resDelay(resDelay), .resOffset(resOffset)
  );
endmodule

// File: rtl/ldmChecker.sv
module ldmChecker #(
  parameter int NUM_LANES = 8,
  localparam int LANE_W = $clog2(NUM_LANES)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 chkStb,
  input logic                 chkMaster,
  input logic                 ackStb,
  input logic [LANE_W-1:0]    ackLane,
  input logic                 resStb,
  input logic [LANE_W-1:0]    resLane,
  input logic [NUM_LANES-1:0] errFlags
);
  // R6
  err_rise_on_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((errFlags & ~$past(errFlags)) != '0) |-> $past(ackStb));
  // R6
  err_single_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(errFlags & ~$past(errFlags)) <= 1);
  // R4
  res_after_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    resStb |-> ($past(ackStb) && resLane == $past(ackLane)));
  // R1
  slave_start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chkStb && !chkMaster && !ackStb) |=> (errFlags == $past(errFlags)));
  // R1
  master_start_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chkStb && chkMaster && !ackStb) |=> (errFlags == '0));
  // R7
  commit_no_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resStb && !$past(chkStb)) |-> (errFlags == $past(errFlags)));
endmodule

bind linkDelayTable ldmChecker #(.NUM_LANES(NUM_LANES)) uChk (
  .clk(clk), .rstN(rstN), .chkStb(chkStb), .chkMaster(chkMaster),
  .ackStb(ackStb), .ackLane(ackLane), .resStb(resStb), .resLane(resLane),
  .errFlags(errFlags)
);

// File: tb/tb_linkDelayTable.sv
module tb_linkDelayTable;
  localparam int NL = 8;
  localparam int DW = 5;
  localparam int TW = 32;
  localparam int LW = $clog2(NL);
  localparam int ND = 1 << DW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chkStb = 0, chkMaster = 0;
  logic [DW-1:0] chkDev = '0;
  logic [TW-1:0] chkT1 = '0;
  logic t2Stb = 0, t3Stb = 0, ackStb = 0;
  logic [LW-1:0] t2Lane = '0, t3Lane = '0, ackLane = '0, rdLane = '0;
  logic [TW-1:0] t2Time = '0, t3Time = '0, ackT4 = '0;
  logic [DW-1:0] rdDev = '0;
  logic rdValid, resStb;
  logic [TW-1:0] rdDelay, resDelay, resOffset;
  logic [LW-1:0] resLane;
  logic [NL-1:0] errFlags;

  linkDelayTable #(.NUM_LANES(NL), .DEV_W(DW), .TS_W(TW)) dut (.*);

  always #2 clk = ~clk;  // 250 MHz

  int total = 0, fails = 0;
  logic [TW-1:0] expTbl [NL][ND];
  logic          expVld [NL][ND];
  logic [TW-1:0] curT1, lT2 [NL], lT3 [NL];
  int curDev;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [TW-1:0] halfSum(input logic [TW-1:0] a, input logic [TW-1:0] b, input bit sub);
    longint s;
    s = sub ? (longint'($signed(a)) - longint'($signed(b))) : (longint'($signed(a)) + longint'($signed(b)));
    return TW'(s >>> 1);
  endfunction

  task automatic doStart(input bit master, input int dev, input logic [TW-1:0] t1);
    @(negedge clk);
    chkStb = 1; chkMaster = master; chkDev = DW'(dev); chkT1 = t1;
    @(negedge clk);
    chkStb = 0; chkMaster = 0;
    if (master) begin curT1 = t1; curDev = dev; end
  endtask

  task automatic capBoth(input int lane, input logic [TW-1:0] a, input logic [TW-1:0] b);
    @(negedge clk);
    t2Stb = 1; t2Lane = LW'(lane); t2Time = a;
    t3Stb = 1; t3Lane = LW'(lane); t3Time = b;
    @(negedge clk);
    t2Stb = 0; t3Stb = 0;
    lT2[lane] = a; lT3[lane] = b;
  endtask

  task automatic capOne(input int lane, input logic [TW-1:0] a);
    @(negedge clk);
    t2Stb = 1; t2Lane = LW'(lane); t2Time = a;
    @(negedge clk);
    t2Stb = 0;
    lT2[lane] = a;
  endtask

  // Acknowledge a lane; good=1 expects a commit, else an error flag
  task automatic doAck(input int lane, input logic [TW-1:0] t4, input bit good, input string req);
    logic [TW-1:0] ed, eo;
    ed = halfSum(lT2[lane] - curT1, t4 - lT3[lane], 0);
    eo = halfSum(lT2[lane] - curT1, t4 - lT3[lane], 1);
    @(negedge clk);
    ackStb = 1; ackLane = LW'(lane); ackT4 = t4;
    @(negedge clk);
    ackStb = 0;
    check(resStb == good, {req, " resStb"}, resStb, good);
    check(errFlags[lane] == !good, {req, " errFlag"}, errFlags[lane], !good);
    if (good) begin
      check(resLane == LW'(lane), "R4 resLane", resLane, lane);
      check(resDelay == ed, "R4 resDelay", resDelay, ed);
      check(resOffset == eo, "R5 resOffset", resOffset, eo);
      expTbl[lane][curDev] = ed;
      expVld[lane][curDev] = 1;
    end
  endtask

  task automatic readChk(input int lane, input int dev, input string req);
    logic [TW-1:0] e;
    @(negedge clk);
    rdLane = LW'(lane); rdDev = DW'(dev);
    @(negedge clk);
    e = expVld[lane][dev] ? expTbl[lane][dev] : '0;
    check(rdValid == expVld[lane][dev], {req, " rdValid"}, rdValid, expVld[lane][dev]);
    check(rdDelay == e, {req, " rdDelay"}, rdDelay, e);
  endtask

  task automatic session(input int dev, input logic [TW-1:0] base);
    doStart(1, dev, base);
    for (int l = 0; l < NL; l++) begin
      int dl, off;
      dl  = 3 + 7 * l + dev;
      off = (l - 3) * 1000 + dev * 13 - 200;
      capBoth(l, base + TW'(dl + off), base + TW'(dl + off + 50 + l)); // R2 R3
    end
    for (int l = 0; l < NL; l++) begin
      int dl, off;
      dl  = 3 + 7 * l + dev;
      off = (l - 3) * 1000 + dev * 13 - 200;
      doAck(l, lT3[l] + TW'(dl - off + (l % 2)), 1, "R4");
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    for (int l = 0; l < NL; l++) begin
      lT2[l] = '0; lT3[l] = '0;
      for (int d = 0; d < ND; d++) begin expTbl[l][d] = '0; expVld[l][d] = 0; end
    end
    curT1 = '0; curDev = 0;
    repeat (4) @(negedge clk);
    rstN = 1;
    // R8: reset state
    check(errFlags == '0, "R8 errFlags reset", errFlags, 0);
    check(resStb == 0, "R8 resStb reset", resStb, 0);
    for (int l = 0; l < NL; l++)
      for (int d = 0; d < ND; d++) readChk(l, d, "R8");

    // R4 R5 sessions across wrap and several initiators
    session(0, 32'hFFFF_FF00);
    session(5, 32'h0000_1234);
    session(31, 32'h7FFF_FFF0);
    session(17, 32'h8000_0005);

    // R6: acknowledgements on incomplete lanes
    doStart(1, 9, 32'h100);
    doAck(2, 32'h500, 0, "R6 no captures");
    capOne(3, 32'h180);
    doAck(3, 32'h500, 0, "R6 only t2");
    // R7: second ack consumes nothing
    capBoth(4, 32'h180, 32'h1A0);
    doAck(4, 32'h220, 1, "R7 first");
    doAck(4, 32'h220, 0, "R7 second");
    // R1: start from a non-master changes nothing
    capBoth(5, 32'h190, 32'h1B0);
    doStart(0, 12, 32'hDEAD_0000);
    check(errFlags[2] && errFlags[3], "R1 slave start kept errors", errFlags, 8'h0C);
    doAck(5, 32'h230, 1, "R1 old t1/dev used");
    // R1: master start clears errors and captures
    doStart(1, 9, 32'h200);
    check(errFlags == '0, "R1 master start clears", errFlags, 0);
    doAck(5, 32'h330, 0, "R1 captures cleared");

    // R9: read during write to the same entry
    doStart(1, 0, 32'h0000_0000);
    capBoth(0, 32'h0000_0040, 32'h0000_0060);
    @(negedge clk);
    rdLane = '0; rdDev = '0;
    ackStb = 1; ackLane = '0; ackT4 = 32'h0000_00A0;
    @(negedge clk);
    ackStb = 0;
    check(rdDelay == expTbl[0][0], "R9 old value on collision", rdDelay, expTbl[0][0]);
    expTbl[0][0] = halfSum(32'h40, 32'h40, 0);
    @(negedge clk);
    check(rdDelay == expTbl[0][0], "R9 new value next cycle", rdDelay, expTbl[0][0]);

    // R10: full sweep against model
    for (int l = 0; l < NL; l++)
      for (int d = 0; d < ND; d++) readChk(l, d, "R10");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule